// File: doc/BRIEF.md
# ADC Conversion Start Controller

This block decides when an analog-to-digital converter begins a conversion. A start can come from a software write pulse or from any of five hardware event lines: an external pin, a timer overflow, an input-capture event, a compare match and a PWM rising edge. Each hardware line has its own enable bit, and any mix of them may be enabled at once. Each line is edge-detected, so one event gives at most one start. A master enable must be high for any start to be accepted.

Once a start is accepted the block raises its busy flag and opens an acquisition window. The window lasts a programmed number of conversion-clock periods, counted on a tick input, and is never shorter than two. When the window ends, the block sends a one-cycle pulse to the conversion sequencer. The busy flag drops when the sequencer reports completion. Start requests that arrive while busy is high are discarded, not queued.

Top module: `adc_start_ctrl`

## Requirements
- R1: After reset, `busy`, `sampling` and `conv_start` are all low.
- R2: A one-cycle `sw_go` pulse while `en` is high sets `busy` and `sampling` in the next cycle.
- R3: A rising edge on `trig_in[i]` starts a conversion only when `trig_en[i]` is 1. The bit order is: 0 external pin, 1 timer overflow, 2 input capture, 3 compare match, 4 PWM rising edge.
- R4: Any set of enabled sources may fire, alone or together with `sw_go` in the same cycle, and this gives exactly one start.
- R5: A trigger line held high gives only one start. A line that is already high when reset is released gives none.
- R6: A start request that arrives while `busy` is high is discarded and does not cause a later conversion.
- R7: The acquisition window is max(`acq_sel`, 2) conversion-clock ticks long. `conv_start` is high for exactly one cycle, in the cycle after the final tick.
- R8: The acquisition count advances only in cycles where `tad_tick` is high.
- R9: `busy` clears in the cycle after `conv_done` is seen while converting. `conv_done` has no effect during acquisition.
- R10: While `en` is low, no start is accepted. Dropping `en` during acquisition or conversion clears `busy` in the next cycle.
- R11: `sampling` is high from the accepted start until the cycle in which `conv_start` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Master enable for the converter |
| sw_go | input | 1 | Software start pulse |
| trig_in | input | 5 | Raw hardware event lines |
| trig_en | input | 5 | Per-line trigger enables |
| acq_sel | input | 4 | Acquisition length in conversion-clock periods (minimum 2) |
| tad_tick | input | 1 | One-cycle pulse for each conversion-clock period |
| conv_done | input | 1 | Sequencer reports that the conversion finished |
| busy | output | 1 | Go/busy flag |
| sampling | output | 1 | Acquisition window active |
| conv_start | output | 1 | One-cycle pulse that begins the conversion |

## Verification
Two functions can meet in one cycle: completion of a conversion and a new trigger edge. They collide when a trigger edge arrives in the same cycle as `conv_done`, which is the last cycle in which `busy` is still high. The bench checks that `busy` falls and stays low, so the trigger was dropped. It also drives `sw_go` together with a hardware edge, and several hardware edges together, and then confirms that only one acquisition and one `conv_start` follow.

// File: rtl/adc_start_pkg.sv
// Package: shared types and constants for the ADC start controller.
// Assumes: the five hardware sources keep a fixed bit order in every vector.
package adc_start_pkg;
    localparam int NUM_SRC      = 5;
    localparam int ACQ_W        = 4;
    localparam int ACQ_MIN      = 2;

    localparam int SRC_PIN      = 0;
    localparam int SRC_TMR_OVF  = 1;
    localparam int SRC_CAPTURE  = 2;
    localparam int SRC_COMPARE  = 3;
    localparam int SRC_PWM      = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACQ  = 2'd1,
        ST_CONV = 2'd2
    } ctl_state_t;
endpackage

// File: rtl/adc_trig_edge.sv
// Module: adc_trig_edge
// Turns each raw trigger line into a one-cycle rising-edge event, masks the
// events with their enables and ORs them into one request.
// Assumes: the inputs are already synchronous to clk. The history register
// resets to ones, so a line that is high at reset gives no edge.
module adc_trig_edge #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] trig_in,
    input  logic [N-1:0] trig_en,
    output logic         fire
);
    logic [N-1:0] prev_q;
    logic [N-1:0] hit;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_src
            // Purpose: keep last cycle's level of one source line.
            always_ff @(posedge clk) begin
                if (!rst_n) prev_q[g] <= 1'b1;
                else        prev_q[g] <= trig_in[g];
            end
            // Purpose: an enabled low-to-high transition on this line.
            assign hit[g] = trig_en[g] & trig_in[g] & ~prev_q[g];
        end
    endgenerate

    // Purpose: any enabled edge requests a start.
    assign fire = |hit;

    assert_edge_needs_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> |(trig_en & trig_in));
endmodule

// File: rtl/adc_acq_timer.sv
// Module: adc_acq_timer
// Counts conversion-clock ticks during the acquisition window and flags the
// final tick. The length is latched when the window opens and is raised to
// MIN when the programmed value is smaller.
// Assumes: load and run are never high in the same cycle.
module adc_acq_timer #(
    parameter int W   = 4,
    parameter int MIN = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] acq_sel,
    input  logic         run,
    input  logic         tad_tick,
    output logic         expire
);
    localparam logic [W-1:0] MIN_V = W'(MIN);

    logic [W-1:0] tgt_q;
    logic [W-1:0] cnt_q;
    logic [W-1:0] last_v;

    // Purpose: latch the clamped window length and clear the count at start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_q <= MIN_V;
            cnt_q <= '0;
        end else if (load) begin
            tgt_q <= (acq_sel < MIN_V) ? MIN_V : acq_sel;
            cnt_q <= '0;
        end else if (run && tad_tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Purpose: the index of the final tick in the window.
    assign last_v = tgt_q - 1'b1;
    // Purpose: flag the tick that ends the window.
    assign expire = run & tad_tick & (cnt_q == last_v);

    assert_tick_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tad_tick && !load) |=> $stable(cnt_q));
    assert_min_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_q >= MIN_V);
endmodule

// File: rtl/adc_go_ctrl.sv
// Module: adc_go_ctrl
// Owns the go/busy flag. It steps from idle through acquisition to
// conversion, issues the conversion start pulse and returns to idle on
// completion or when the converter is disabled.
// Assumes: start requests are level for one cycle and are ignored when not idle.
module adc_go_ctrl
    import adc_start_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic start_req,
    input  logic acq_expire,
    input  logic conv_done,
    output logic acq_load,
    output logic acq_run,
    output logic busy,
    output logic sampling,
    output logic conv_start
);
    ctl_state_t state_q, state_d;
    logic       start_d;

    // Purpose: compute the next state and the start pulse.
    always_comb begin
        state_d = state_q;
        start_d = 1'b0;
        unique case (state_q)
            ST_IDLE: if (en && start_req) state_d = ST_ACQ;
            ST_ACQ: begin
                if (!en) state_d = ST_IDLE;
                else if (acq_expire) begin
                    state_d = ST_CONV;
                    start_d = 1'b1;
                end
            end
            ST_CONV: begin
                if (!en || conv_done) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Purpose: register the state and the start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            conv_start <= 1'b0;
        end else begin
            state_q    <= state_d;
            conv_start <= start_d;
        end
    end

    // Purpose: decode the flags from the state.
    assign busy     = (state_q != ST_IDLE);
    assign sampling = (state_q == ST_ACQ);
    assign acq_load = (state_q == ST_IDLE) && en && start_req;
    assign acq_run  = sampling;

    assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);
    assert_start_after_acq_R11: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> $past(sampling));
    assert_go_needs_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(en));
    assert_off_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !busy);
    assert_done_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !sampling && conv_done) |=> !busy);
    assert_done_ignored_acq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sampling && en && !acq_expire) |=> sampling);
endmodule

// File: rtl/adc_start_ctrl.sv
// Module: adc_start_ctrl (top)
// Combines the software and hardware start requests, times the acquisition
// window and hands a start pulse to the conversion sequencer.
// Assumes: all inputs are synchronous to clk, and tad_tick is a one-cycle pulse.
module adc_start_ctrl
    import adc_start_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               sw_go,
    input  logic [NUM_SRC-1:0] trig_in,
    input  logic [NUM_SRC-1:0] trig_en,
    input  logic [ACQ_W-1:0]   acq_sel,
    input  logic               tad_tick,
    input  logic               conv_done,
    output logic               busy,
    output logic               sampling,
    output logic               conv_start
);
    logic hw_fire;
    logic start_req;
    logic acq_load;
    logic acq_run;
    logic acq_expire;

    adc_trig_edge #(.N(NUM_SRC)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig_in (trig_in),
        .trig_en (trig_en),
        .fire    (hw_fire)
    );

    // Purpose: merge the software and hardware requests into one.
    assign start_req = sw_go | hw_fire;

    adc_acq_timer #(.W(ACQ_W), .MIN(ACQ_MIN)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (acq_load),
        .acq_sel  (acq_sel),
        .run      (acq_run),
        .tad_tick (tad_tick),
        .expire   (acq_expire)
    );

    adc_go_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .start_req  (start_req),
        .acq_expire (acq_expire),
        .conv_done  (conv_done),
        .acq_load   (acq_load),
        .acq_run    (acq_run),
        .busy       (busy),
        .sampling   (sampling),
        .conv_start (conv_start)
    );

    assert_busy_covers_sampling_R11: assert property (@(posedge clk) disable iff (!rst_n)
        sampling |-> busy);
endmodule

// File: tb/sim_adc_start_ctrl.sv
module sim_adc_start_ctrl;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic       en;
        logic [4:0] ten;
        logic [4:0] pulse;
        logic       sw;
        logic [3:0] acq;
        logic       go;
    } vec_t;

    // bit order: 0 pin, 1 timer overflow, 2 capture, 3 compare, 4 PWM
    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 5'h00, 5'h00, 1'b1, 4'd0,  1'b1},
        '{1'b1, 5'h01, 5'h01, 1'b0, 4'd5,  1'b1},
        '{1'b1, 5'h01, 5'h02, 1'b0, 4'd3,  1'b0},
        '{1'b1, 5'h04, 5'h04, 1'b0, 4'd1,  1'b1},
        '{1'b1, 5'h08, 5'h08, 1'b0, 4'd15, 1'b1},
        '{1'b1, 5'h1F, 5'h10, 1'b0, 4'd3,  1'b1},
        '{1'b1, 5'h1F, 5'h11, 1'b0, 4'd2,  1'b1},
        '{1'b0, 5'h1F, 5'h1F, 1'b1, 4'd2,  1'b0},
        '{1'b1, 5'h02, 5'h02, 1'b1, 4'd4,  1'b1},
        '{1'b1, 5'h00, 5'h1F, 1'b0, 4'd2,  1'b0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       sw_go = 1'b0;
    logic [4:0] trig_in = '0;
    logic [4:0] trig_en = '0;
    logic [3:0] acq_sel = '0;
    logic       tad_tick = 1'b1;
    logic       conv_done = 1'b0;
    logic       busy, sampling, conv_start;

    int checks = 0;
    int errors = 0;

    adc_start_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .sw_go(sw_go), .trig_in(trig_in),
        .trig_en(trig_en), .acq_sel(acq_sel), .tad_tick(tad_tick),
        .conv_done(conv_done), .busy(busy), .sampling(sampling),
        .conv_start(conv_start)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    task automatic wait_conv(output int k);
        k = 0;
        for (int i = 1; i <= 40; i++) begin
            @(negedge clk);
            if (conv_start) begin
                k = i;
                break;
            end
        end
    endtask

    task automatic finish_conv(input string req);
        conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
        chk(busy == 1'b0, req, int'(busy), 0);
    endtask

    task automatic sw_start(input logic [3:0] a);
        acq_sel = a;
        sw_go = 1'b1;
        @(negedge clk);
        sw_go = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        summary();
        $finish;
    end

    initial begin
        int k;
        int lat;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!busy && !sampling && !conv_start, "R1 reset outputs", int'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy, "R1 idle after reset", int'(busy), 0);

        // table walk: R2 R3 R4 R7 R9 R10
        for (int v = 0; v < NV; v++) begin
            en = VECS[v].en;
            trig_en = VECS[v].ten;
            acq_sel = VECS[v].acq;
            trig_in = VECS[v].pulse;
            sw_go = VECS[v].sw;
            @(negedge clk);
            trig_in = '0;
            sw_go = 1'b0;
            chk(busy == VECS[v].go, $sformatf("R2/R3/R10 vec %0d busy", v), int'(busy), int'(VECS[v].go));
            if (VECS[v].go) begin
                chk(sampling, $sformatf("R11 vec %0d sampling", v), int'(sampling), 1);
                lat = (VECS[v].acq < 2) ? 2 : int'(VECS[v].acq);
                wait_conv(k);
                chk(k == lat, $sformatf("R7 vec %0d latency", v), k, lat);
                chk(!sampling, "R11 sampling ends at start", int'(sampling), 0);
                finish_conv("R9 busy clears");
                repeat (3) @(negedge clk);
                chk(!busy, $sformatf("R4 vec %0d single start", v), int'(busy), 0);
            end else begin
                repeat (3) @(negedge clk);
                chk(!busy, $sformatf("R3/R10 vec %0d no start", v), int'(busy), 0);
            end
            en = 1'b1;
            @(negedge clk);
        end

        // R5 held level: one start only
        trig_en = 5'h01;
        acq_sel = 4'd2;
        trig_in = 5'h01;
        @(negedge clk);
        chk(busy, "R5 first edge starts", int'(busy), 1);
        wait_conv(k);
        finish_conv("R9 held-level finish");
        repeat (5) @(negedge clk);
        chk(!busy, "R5 held level no restart", int'(busy), 0);
        // R5 level high across reset release
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!busy, "R5 high at reset no start", int'(busy), 0);
        trig_in = '0;
        @(negedge clk);

        // R6 trigger during busy dropped
        sw_start(4'd8);
        trig_in = 5'h01;
        @(negedge clk);
        trig_in = '0;
        wait_conv(k);
        chk(k == 7, "R6 window unaffected", k, 7);
        finish_conv("R9 finish");
        repeat (4) @(negedge clk);
        chk(!busy, "R6 dropped trigger", int'(busy), 0);

        // same cycle: completion and new trigger edge
        sw_start(4'd2);
        wait_conv(k);
        conv_done = 1'b1;
        trig_in = 5'h01;
        @(negedge clk);
        conv_done = 1'b0;
        trig_in = '0;
        chk(!busy, "R9 collision clears", int'(busy), 0);
        repeat (3) @(negedge clk);
        chk(!busy, "R6 collision trigger dropped", int'(busy), 0);

        // R8 ticks gate the count, R9 done ignored during acquisition
        tad_tick = 1'b0;
        sw_start(4'd3);
        conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
        repeat (8) @(negedge clk);
        chk(sampling && !conv_start, "R8 no ticks no progress", int'(sampling), 1);
        chk(busy, "R9 done ignored in acquisition", int'(busy), 1);
        tad_tick = 1'b1;
        wait_conv(k);
        tad_tick = 1'b1;
        chk(k == 3, "R8 three ticks", k, 3);

        // R10 disable during conversion aborts
        en = 1'b0;
        @(negedge clk);
        chk(!busy, "R10 abort in conversion", int'(busy), 0);
        en = 1'b1;
        sw_start(4'd6);
        en = 1'b0;
        @(negedge clk);
        chk(!busy && !sampling, "R10 abort in acquisition", int'(busy), 0);
        en = 1'b1;
        repeat (10) @(negedge clk);
        chk(!conv_start && !busy, "R10 no late start", int'(conv_start), 0);

        summary();
        $finish;
    end
endmodule